// File: doc/BRIEF.md
# Byte ALU with Selective Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. It accepts two byte operands, the current status flags and an operation code. It returns a byte result, a new flag vector and a write-back strobe. Each operation changes only its own subset of the flags. Every flag it does not touch is copied from the incoming flag vector, so the caller can keep one status register and feed it back each time.

Operations enter and leave through valid/ready handshakes, with one register stage between them. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output stage holds its contents and refuses new input. The flag vector uses these bit positions: C=0, Z=1, N=2, V=3, S=4, H=5. The operation codes are listed with the requirements below.

Top module: `alu8_core`

## Requirements
- R1: Add (op 0) computes a+b. Add-with-carry (op 1) computes a+b+C_in. Both update C (carry out of bit 7), Z, N, V (operands share a sign and the result sign differs) and H (carry out of bit 3).
- R2: Subtract (op 2) and compare (op 4) compute a-b. Subtract-with-carry (op 3) and compare-with-carry (op 5) compute a-b-C_in. All four update C (borrow), Z, N, V (operand signs differ and the result sign differs from a) and H (borrow out of bit 3).
- R3: For ops 3 and 5, Z is cleared when the result is nonzero and otherwise keeps its incoming value.
- R4: `out_wr` is 0 for ops 4 and 5 and for unassigned codes. It is 1 for every other assigned op.
- R5: AND (op 6), OR (op 7) and XOR (op 8) update Z and N and force V to 0. C and H keep their incoming values.
- R6: One's complement (op 9) gives 0xFF-a, sets C, clears V and keeps H. Two's complement (op 10) gives 0x00-a and updates C, Z, N, V and H as a subtraction from zero.
- R7: Increment (op 11) and decrement (op 12) update only Z, N and V. V is set on the 0x7F→0x80 and 0x80→0x7F crossings.
- R8: Shift left (op 13) and rotate left (op 15) put bit 7 into C and bit 3 into H. Bit 0 receives 0 for the shift and the old C for the rotate. Shift right (op 14) and rotate right (op 16) put bit 0 into C. Bit 7 receives 0 for the shift and the old C for the rotate. All four set V to N xor C.
- R9: Arithmetic shift right (op 17) keeps bit 7, moves bits 7..1 down one place and puts bit 0 into C. V is N xor C.
- R10: Nibble swap (op 18) exchanges bits 3:0 and 7:4. Set-all (op 19) yields 0xFF. Neither changes any flag.
- R11: S equals N xor V after every op that updates N or V. Otherwise S keeps its incoming value.
- R12: The result is on the outputs on the rising edge after acceptance. While `out_ready` is low, the outputs stay stable and `in_ready` is low.
- R13: After reset, `out_valid` is 0.
- R14: An unassigned code (20 to 31) returns operand a with the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_op | input | 5 | Operation code |
| in_a | input | 8 | First operand / destination value |
| in_b | input | 8 | Second operand |
| in_flags | input | 6 | Current status flags |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 8 | Result byte |
| out_flags | output | 6 | New status flags |
| out_wr | output | 1 | Result is to be written back |

## Verification
Each result and flag vector appears one rising edge after its acceptance edge and stays there until it is consumed. The bench therefore drives each operation on a falling edge, lets one rising edge accept it, and compares the outputs on the following falling edge. In the stall test, `out_ready` is held low across extra rising edges. The held outputs are checked there, and the next result is expected one edge after `out_ready` returns high.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int FLAG_W = 6;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,  OP_CPC  = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
    OP_XOR  = 5'd8,  OP_COM  = 5'd9,  OP_NEG  = 5'd10, OP_INC  = 5'd11,
    OP_DEC  = 5'd12, OP_LSL  = 5'd13, OP_LSR  = 5'd14, OP_ROL  = 5'd15,
    OP_ROR  = 5'd16, OP_ASR  = 5'd17, OP_SWAP = 5'd18, OP_SER  = 5'd19
  } alu_op_e;

  // Flags an op writes; S is derived separately from N and V.
  function automatic logic [FLAG_W-1:0] touch_mask(input logic [4:0] op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC,
      OP_NEG, OP_LSL, OP_ROL:                  touch_mask = 6'b10_1111;
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:   touch_mask = 6'b00_1110;
      OP_COM, OP_LSR, OP_ROR, OP_ASR:          touch_mask = 6'b00_1111;
      default:                                 touch_mask = 6'b00_0000;
    endcase
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         cy,
  output logic         hc,
  output logic         ov
);
  localparam int HB = W / 2;

  logic [W:0]  full;
  logic [HB:0] half;

  always_comb begin
    if (sub) begin
      full = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};
      half = {1'b0, x[HB-1:0]} - {1'b0, y[HB-1:0]} - {{HB{1'b0}}, cin};
    end else begin
      full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
      half = {1'b0, x[HB-1:0]} + {1'b0, y[HB-1:0]} + {{HB{1'b0}}, cin};
    end
    res = full[W-1:0];
    cy  = full[W];
    hc  = half[HB];
    if (sub) ov = (x[W-1] ^ y[W-1]) & (full[W-1] ^ x[W-1]);
    else     ov = ~(x[W-1] ^ y[W-1]) & (full[W-1] ^ x[W-1]);
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cy,
  output logic         hc,
  output logic         ov
);
  localparam int HB = W / 2;

  logic shifter;

  always_comb begin
    res     = a;
    cy      = cin;
    hc      = 1'b0;
    shifter = 1'b0;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_COM:  begin res = ~a; cy = 1'b1; end
      OP_LSL:  begin res = {a[W-2:0], 1'b0}; cy = a[W-1]; hc = a[HB-1]; shifter = 1'b1; end
      OP_ROL:  begin res = {a[W-2:0], cin};  cy = a[W-1]; hc = a[HB-1]; shifter = 1'b1; end
      OP_LSR:  begin res = {1'b0, a[W-1:1]};   cy = a[0]; shifter = 1'b1; end
      OP_ROR:  begin res = {cin, a[W-1:1]};    cy = a[0]; shifter = 1'b1; end
      OP_ASR:  begin res = {a[W-1], a[W-1:1]}; cy = a[0]; shifter = 1'b1; end
      OP_SWAP: res = {a[HB-1:0], a[W-1:HB]};
      OP_SER:  res = {W{1'b1}};
      default: ;
    endcase
    ov = shifter ? (res[W-1] ^ cy) : 1'b0;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [4:0]        in_op,
  input  logic [W-1:0]      in_a,
  input  logic [W-1:0]      in_b,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_result,
  output logic [FLAG_W-1:0] out_flags,
  output logic              out_wr
);
  logic [W-1:0] ax, ay, as_res, bo_res, res;
  logic         as_cin, as_sub, as_cy, as_hc, as_ov;
  logic         bo_cy, bo_hc, bo_ov;
  logic         is_arith, chain_z, known;
  logic         c_n, h_n, v_n, n_n, z_n;
  logic [FLAG_W-1:0] mask, nf;
  logic         accept;

  // operand steering for the shared adder/subtractor
  always_comb begin
    ax = in_a; ay = in_b; as_cin = 1'b0; as_sub = 1'b0;
    is_arith = 1'b1; chain_z = 1'b0; known = 1'b1;
    case (in_op)
      OP_ADD: ;
      OP_ADC: as_cin = in_flags[FC];
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_SBC, OP_CPC: begin as_sub = 1'b1; as_cin = in_flags[FC]; chain_z = 1'b1; end
      OP_NEG: begin ax = '0; ay = in_a; as_sub = 1'b1; end
      OP_INC: ay = {{(W-1){1'b0}}, 1'b1};
      OP_DEC: begin ay = {{(W-1){1'b0}}, 1'b1}; as_sub = 1'b1; end
      OP_AND, OP_OR, OP_XOR, OP_COM, OP_LSL, OP_LSR,
      OP_ROL, OP_ROR, OP_ASR, OP_SWAP, OP_SER: is_arith = 1'b0;
      default: begin is_arith = 1'b0; known = 1'b0; end
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .x(ax), .y(ay), .cin(as_cin), .sub(as_sub),
    .res(as_res), .cy(as_cy), .hc(as_hc), .ov(as_ov)
  );

  alu8_bitops #(.W(W)) u_bitops (
    .op(in_op), .a(in_a), .b(in_b), .cin(in_flags[FC]),
    .res(bo_res), .cy(bo_cy), .hc(bo_hc), .ov(bo_ov)
  );

  // flag merge: untouched flags pass through
  always_comb begin
    mask = touch_mask(in_op);
    res  = is_arith ? as_res : bo_res;
    c_n  = is_arith ? as_cy  : bo_cy;
    h_n  = is_arith ? as_hc  : bo_hc;
    v_n  = is_arith ? as_ov  : bo_ov;
    n_n  = res[W-1];
    z_n  = (res == '0) & (chain_z ? in_flags[FZ] : 1'b1);
    nf     = in_flags;
    nf[FC] = mask[FC] ? c_n : in_flags[FC];
    nf[FZ] = mask[FZ] ? z_n : in_flags[FZ];
    nf[FN] = mask[FN] ? n_n : in_flags[FN];
    nf[FV] = mask[FV] ? v_n : in_flags[FV];
    nf[FH] = mask[FH] ? h_n : in_flags[FH];
    nf[FS] = (mask[FN] | mask[FV]) ? (nf[FN] ^ nf[FV]) : in_flags[FS];
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
      out_wr     <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= res;
      out_flags  <= nf;
      out_wr     <= known && (in_op != OP_CMP) && (in_op != OP_CPC);
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flags) && $stable(out_wr));

  // R4
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_op == OP_CMP || in_op == OP_CPC) |=> !out_wr);

  // R5
  logic_vclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_op == OP_AND || in_op == OP_OR || in_op == OP_XOR) |=> !out_flags[FV]);

  // R10
  swap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == OP_SWAP |=> out_flags == $past(in_flags));

  // R11
  sign_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == OP_ADD |=> out_flags[FS] == (out_flags[FN] ^ out_flags[FV]));

  // R13
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);
endmodule

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [4:0] in_op = '0;
  logic [7:0] in_a = '0, in_b = '0;
  logic [5:0] in_flags = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result;
  logic [5:0] out_flags;
  logic       out_wr;
  int applied = 0;
  int bad = 0;

  always #2 clk = ~clk;

  alu8_core dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_flags(out_flags), .out_wr(out_wr)
  );

  // {op, a, b, flags_in, result, flags_out, wr}; flags C0 Z1 N2 V3 S4 H5
  localparam int NV = 24;
  localparam logic [41:0] VEC [NV] = '{
    {5'd0,  8'h0F, 8'h01, 6'h00, 8'h10, 6'h20, 1'b1},  // R1 half carry
    {5'd0,  8'h7F, 8'h01, 6'h00, 8'h80, 6'h2C, 1'b1},  // R1 overflow
    {5'd1,  8'hFF, 8'h00, 6'h01, 8'h00, 6'h23, 1'b1},  // R1 carry in
    {5'd2,  8'h00, 8'h01, 6'h00, 8'hFF, 6'h35, 1'b1},  // R2 borrow
    {5'd3,  8'h80, 8'h00, 6'h01, 8'h7F, 6'h38, 1'b1},  // R2 overflow
    {5'd5,  8'h05, 8'h05, 6'h02, 8'h00, 6'h02, 1'b0},  // R3 Z kept set
    {5'd5,  8'h05, 8'h05, 6'h00, 8'h00, 6'h00, 1'b0},  // R3 Z stays clear
    {5'd4,  8'h10, 8'h20, 6'h00, 8'hF0, 6'h15, 1'b0},  // R4 compare
    {5'd6,  8'hF0, 8'h0F, 6'h29, 8'h00, 6'h23, 1'b1},  // R5 and
    {5'd7,  8'h80, 8'h01, 6'h08, 8'h81, 6'h14, 1'b1},  // R5 or
    {5'd8,  8'hAA, 8'hAA, 6'h3F, 8'h00, 6'h23, 1'b1},  // R5 xor
    {5'd9,  8'h0F, 8'h00, 6'h00, 8'hF0, 6'h15, 1'b1},  // R6 com
    {5'd10, 8'h80, 8'h00, 6'h00, 8'h80, 6'h0D, 1'b1},  // R6 neg 0x80
    {5'd10, 8'h00, 8'h00, 6'h01, 8'h00, 6'h02, 1'b1},  // R6 neg zero
    {5'd11, 8'h7F, 8'h00, 6'h21, 8'h80, 6'h2D, 1'b1},  // R7 inc
    {5'd12, 8'h80, 8'h00, 6'h00, 8'h7F, 6'h18, 1'b1},  // R7 dec
    {5'd12, 8'h01, 8'h00, 6'h01, 8'h00, 6'h03, 1'b1},  // R7 dec to zero
    {5'd13, 8'h88, 8'h00, 6'h00, 8'h10, 6'h39, 1'b1},  // R8 lsl
    {5'd14, 8'h01, 8'h00, 6'h00, 8'h00, 6'h1B, 1'b1},  // R8 lsr
    {5'd15, 8'h40, 8'h00, 6'h01, 8'h81, 6'h0C, 1'b1},  // R8 rol
    {5'd16, 8'h02, 8'h00, 6'h01, 8'h81, 6'h0C, 1'b1},  // R8 ror
    {5'd17, 8'h81, 8'h00, 6'h00, 8'hC0, 6'h15, 1'b1},  // R9 asr
    {5'd18, 8'h3C, 8'h00, 6'h15, 8'hC3, 6'h15, 1'b1},  // R10 swap
    {5'd19, 8'h12, 8'h00, 6'h2A, 8'hFF, 6'h2A, 1'b1}   // R10 set all
  };

  task automatic check(input string req, input logic [7:0] r, input logic [5:0] f,
                       input logic w);
    applied++;
    if (out_valid !== 1'b1 || out_result !== r || out_flags !== f || out_wr !== w) begin
      bad++;
      $display("FAIL %s: got v=%0b r=%h f=%h w=%0b, expected v=1 r=%h f=%h w=%0b",
               req, out_valid, out_result, out_flags, out_wr, r, f, w);
    end
  endtask

  task automatic offer(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [5:0] f);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_flags = f;
  endtask

  initial begin
    #80000;
    bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: idle after reset
    applied++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R13: got out_valid=%0b expected 0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      offer(VEC[i][41:37], VEC[i][36:29], VEC[i][28:21], VEC[i][20:15]);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("vector %0d", i), VEC[i][14:7], VEC[i][6:1], VEC[i][0]);
    end

    // R14: unassigned code passes a, keeps flags, no write
    offer(5'd25, 8'h5A, 8'h33, 6'h15);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check("R14", 8'h5A, 6'h15, 1'b0);

    // R12: stall holds output and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    offer(5'd0, 8'h0F, 8'h01, 6'h00);
    @(posedge clk); @(negedge clk);
    offer(5'd19, 8'h00, 8'h00, 6'h00);
    applied++;
    if (in_ready !== 1'b0) begin
      bad++;
      $display("FAIL R12: got in_ready=%0b expected 0", in_ready);
    end
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R12 held", 8'h10, 6'h20, 1'b1);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check("R12 released", 8'hFF, 6'h00, 1'b1);
    @(posedge clk); @(negedge clk);
    applied++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R12: got out_valid=%0b after drain, expected 0", out_valid);
    end

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule